// File: doc/BRIEF.md
# Power-of-Two Periodic Interrupt Divider

This block divides a 32.768 kHz time base, given as a one-cycle enable pulse (`tick_en`) on the system clock, into a programmable periodic event. A 4-bit rate code selects a period of 2^(n-1) time-base pulses. Code 0 turns the events off. Codes 1 and 2 are aliases for the slower codes 8 and 9. A free-running 15-bit prescaler counts the time-base pulses. An event fires whenever the low bits of that count roll over to zero, so events stay aligned to whole multiples of the period. A change of rate never restarts the count.

Every event sets a sticky periodic flag, whether or not the interrupt enable is set. The interrupt request follows the flag, but only while the enable is set. Software clears both with a one-cycle clear pulse. The block sits behind a register file, which supplies the rate code, the enable and the clear pulse, and which reads the flag back.

Top module: `periodic_irq_divider`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released, `per_flag` and `irq_req` are 0 and the prescaler count is 0.
- R2: With `rate_sel` = 0, no event occurs and `per_flag` never rises, whatever the other inputs do.
- R3: For `rate_sel` = n with 3 <= n <= 15, an event occurs on every `tick_en` pulse that brings the incremented prescaler count to a value whose low n-1 bits are all zero. This gives a period of 2^(n-1) pulses, from 4 pulses for n=3 up to 16384 pulses for n=15.
- R4: `rate_sel` = 1 gives the same events as code 8 (a period of 128 pulses), and `rate_sel` = 2 gives the same events as code 9 (a period of 256 pulses).
- R5: A change of `rate_sel` does not reset the prescaler. The next event falls on the next multiple of the new period in the running count, not one full period after the change.
- R6: An event sets `per_flag` at the clock edge where it is sampled, even when `per_en` is 0. The flag then stays at 1 until a cycle with `flag_clr` = 1 and no event, after which it is 0.
- R7: When `flag_clr` and an event coincide in the same cycle, `per_flag` is 1 after that edge.
- R8: After each clock edge, `irq_req` equals the `per_en` value sampled at that edge ANDed with the new `per_flag`. It is 0 whenever the enable was 0. Setting the enable while the flag is pending raises the request after the next edge.
- R9: The prescaler advances by one, modulo 2^15, only on cycles with `tick_en` = 1. On all other cycles it holds, and no event occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | One-cycle pulse at the 32.768 kHz time-base rate |
| rate_sel | input | 4 | Rate code (0 = off, 1 and 2 alias to 8 and 9) |
| per_en | input | 1 | Periodic interrupt enable |
| flag_clr | input | 1 | One-cycle clear of the flag and the request |
| per_flag | output | 1 | Sticky periodic event flag |
| irq_req | output | 1 | Interrupt request, gated by the enable |

## Verification
The embedded properties check the local rules on every cycle:
- the prescaler steps by exactly one or holds,
- an event only lands on a count aligned to the current mask, and never with code 0,
- an event always leaves the flag set,
- a clear without an event leaves it clear,
- the request never stands without the flag or after the enable was low.

Some behaviour cannot be seen in any single cycle, and only the scenarios show it:
- the exact period for each code,
- the aliasing of codes 1 and 2,
- the phase kept across a rate change,
- the delayed request once the enable is set over a pending flag.

For these, the bench runs a cycle-exact reference and compares against it on every cycle.

// File: rtl/pirq_pkg.sv
package pirq_pkg;

   // Default geometry of the divider.
   localparam int unsigned PIRQ_PRESC_W = 15;
   localparam int unsigned PIRQ_RATE_W  = 4;

   // Low codes that alias to slower codes: code c in [1, ALIAS_MAX] acts as c + ALIAS_ADD.
   localparam int unsigned PIRQ_ALIAS_MAX = 2;
   localparam int unsigned PIRQ_ALIAS_ADD = 7;

   // Reason for the next flag state, used in the flag controller.
   typedef enum logic [1:0] {
      FLG_HOLD  = 2'd0,
      FLG_SET   = 2'd1,
      FLG_CLEAR = 2'd2
   } flag_act_e;

endpackage

// File: rtl/pirq_rate_decode.sv
module pirq_rate_decode #(
   parameter int unsigned RATE_W    = pirq_pkg::PIRQ_RATE_W,
   parameter int unsigned PRESC_W   = pirq_pkg::PIRQ_PRESC_W,
   parameter bit          ALIAS_EN  = 1'b1,
   parameter int unsigned ALIAS_MAX = pirq_pkg::PIRQ_ALIAS_MAX,
   parameter int unsigned ALIAS_ADD = pirq_pkg::PIRQ_ALIAS_ADD
) (
   input  logic [RATE_W-1:0]  rate_sel,
   output logic               valid_o,
   output logic [PRESC_W-1:0] mask_o
);
   localparam int unsigned EFF_W = RATE_W + 1;

   logic [EFF_W-1:0] eff;

   // Variant choice: aliased low codes or a plain linear code.
   generate
      if (ALIAS_EN) begin : g_alias
         always_comb begin
            if (rate_sel != '0 && rate_sel <= RATE_W'(ALIAS_MAX))
               eff = EFF_W'(rate_sel) + EFF_W'(ALIAS_ADD);
            else
               eff = EFF_W'(rate_sel);
         end
      end else begin : g_plain
         always_comb eff = EFF_W'(rate_sel);
      end
   endgenerate

   assign valid_o = (eff != '0);

   // The mask covers the low (eff-1) bits of the prescaler.
   always_comb begin
      for (int b = 0; b < PRESC_W; b++) begin
         mask_o[b] = valid_o && (b < (int'(eff) - 1));
      end
   end

endmodule

// File: rtl/pirq_prescaler.sv
module pirq_prescaler #(
   parameter int unsigned PRESC_W = pirq_pkg::PIRQ_PRESC_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               tick_en,
   output logic [PRESC_W-1:0] cnt_o,
   output logic [PRESC_W-1:0] cnt_inc_o
);
   logic [PRESC_W-1:0] cnt_q;

   assign cnt_inc_o = cnt_q + PRESC_W'(1);
   assign cnt_o     = cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n)       cnt_q <= '0;
      else if (tick_en) cnt_q <= cnt_inc_o;
   end

   // R9: one step per time-base pulse.
   p_count_step_r9 : assert property (@(posedge clk) disable iff (!rst_n)
      tick_en |=> (cnt_q == $past(cnt_q) + PRESC_W'(1)));

   // R9: frozen without a pulse.
   p_count_hold_r9 : assert property (@(posedge clk) disable iff (!rst_n)
      !tick_en |=> $stable(cnt_q));

endmodule

// File: rtl/pirq_tick_gen.sv
module pirq_tick_gen #(
   parameter int unsigned PRESC_W = pirq_pkg::PIRQ_PRESC_W
) (
   input  logic               tick_en,
   input  logic               valid,
   input  logic [PRESC_W-1:0] mask,
   input  logic [PRESC_W-1:0] cnt_inc,
   output logic               tick_o
);
   logic aligned;

   assign aligned = ((cnt_inc & mask) == '0);
   assign tick_o  = tick_en && valid && aligned;

endmodule

// File: rtl/pirq_flag_ctl.sv
module pirq_flag_ctl (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic per_en,
   input  logic flag_clr,
   output logic flag_o,
   output logic irq_o
);
   import pirq_pkg::*;

   flag_act_e act;
   logic      flag_q, irq_q, flag_nxt;

   // A new event outranks a clear in the same cycle.
   always_comb begin
      if (tick)          act = FLG_SET;
      else if (flag_clr) act = FLG_CLEAR;
      else               act = FLG_HOLD;
   end

   always_comb begin
      unique case (act)
         FLG_SET:   flag_nxt = 1'b1;
         FLG_CLEAR: flag_nxt = 1'b0;
         default:   flag_nxt = flag_q;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         flag_q <= 1'b0;
         irq_q  <= 1'b0;
      end else begin
         flag_q <= flag_nxt;
         irq_q  <= per_en & flag_nxt;
      end
   end

   assign flag_o = flag_q;
   assign irq_o  = irq_q;

   // R6, R7: an event always leaves the flag set.
   p_event_sets_flag_r6 : assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> flag_q);

   // R6: a clear without an event empties the flag.
   p_clear_empties_r6 : assert property (@(posedge clk) disable iff (!rst_n)
      (flag_clr && !tick) |=> !flag_q);

   // R8: the request needs the enable.
   p_irq_gated_r8 : assert property (@(posedge clk) disable iff (!rst_n)
      !per_en |=> !irq_q);

   // R8: the request never stands without the flag.
   p_irq_has_flag_r8 : assert property (@(posedge clk) disable iff (!rst_n)
      irq_q |-> flag_q);

endmodule

// File: rtl/periodic_irq_divider.sv
module periodic_irq_divider #(
   parameter int unsigned RATE_W    = pirq_pkg::PIRQ_RATE_W,
   parameter int unsigned PRESC_W   = pirq_pkg::PIRQ_PRESC_W,
   parameter bit          ALIAS_EN  = 1'b1,
   parameter int unsigned ALIAS_MAX = pirq_pkg::PIRQ_ALIAS_MAX,
   parameter int unsigned ALIAS_ADD = pirq_pkg::PIRQ_ALIAS_ADD
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_en,
   input  logic [RATE_W-1:0] rate_sel,
   input  logic              per_en,
   input  logic              flag_clr,
   output logic              per_flag,
   output logic              irq_req
);
   localparam int unsigned MAX_CODE = (1 << RATE_W) - 1;

   // Elaboration-time geometry checks.
   generate
      if (RATE_W < 1 || RATE_W > 6) begin : g_bad_rate_w
         $error("periodic_irq_divider: RATE_W out of range");
      end
      if (PRESC_W < MAX_CODE - 1) begin : g_bad_presc_w
         $error("periodic_irq_divider: prescaler too narrow for the largest code");
      end
      if (ALIAS_EN && (ALIAS_MAX + ALIAS_ADD > MAX_CODE)) begin : g_bad_alias
         $error("periodic_irq_divider: alias target exceeds the code range");
      end
   endgenerate

   logic               valid;
   logic [PRESC_W-1:0] mask;
   logic [PRESC_W-1:0] cnt, cnt_inc;
   logic               tick;

   pirq_rate_decode #(
      .RATE_W(RATE_W), .PRESC_W(PRESC_W), .ALIAS_EN(ALIAS_EN),
      .ALIAS_MAX(ALIAS_MAX), .ALIAS_ADD(ALIAS_ADD)
   ) u_decode (
      .rate_sel(rate_sel),
      .valid_o (valid),
      .mask_o  (mask)
   );

   pirq_prescaler #(.PRESC_W(PRESC_W)) u_presc (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick_en  (tick_en),
      .cnt_o    (cnt),
      .cnt_inc_o(cnt_inc)
   );

   pirq_tick_gen #(.PRESC_W(PRESC_W)) u_tick (
      .tick_en(tick_en),
      .valid  (valid),
      .mask   (mask),
      .cnt_inc(cnt_inc),
      .tick_o (tick)
   );

   pirq_flag_ctl u_flag (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick    (tick),
      .per_en  (per_en),
      .flag_clr(flag_clr),
      .flag_o  (per_flag),
      .irq_o   (irq_req)
   );

   // R2: code 0 never yields an event.
   p_code0_quiet_r2 : assert property (@(posedge clk) disable iff (!rst_n)
      (rate_sel == '0) |-> !tick);

   // R5: an event lands on a count aligned to the period in force.
   p_tick_aligned_r5 : assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> ((cnt & $past(mask)) == '0));

endmodule

// File: tb/periodic_irq_divider_tb_top.sv
module periodic_irq_divider_tb_top;
   localparam time CLK_P = 10ns;

   logic       clk = 1'b0;
   logic       rst_n;
   logic       tick_en, per_en, flag_clr;
   logic [3:0] rate_sel;
   logic       per_flag, irq_req;

   always #(CLK_P/2) clk = ~clk;

   periodic_irq_divider dut_i (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .rate_sel(rate_sel),
      .per_en(per_en), .flag_clr(flag_clr), .per_flag(per_flag), .irq_req(irq_req)
   );

   typedef struct {
      logic  f;
      logic  i;
      string tag;
   } exp_t;

   exp_t        exp_q[$];
   int          n_vec  = 0;
   int          n_miss = 0;
   bit          done   = 1'b0;
   logic [14:0] m_cnt;
   logic        m_flag;

   // Reference model, taken from the requirements.
   function automatic int eff_code(int code);
      if (code == 1 || code == 2) return code + 7;   // R4
      return code;
   endfunction

   task automatic step(input logic te, input logic [3:0] rs, input logic en,
                       input logic clr, input string tag);
      int          n;
      logic        ev;
      logic [14:0] msk;
      exp_t        e;
      tick_en  = te;
      rate_sel = rs;
      per_en   = en;
      flag_clr = clr;
      n   = eff_code(int'(rs));
      ev  = 1'b0;
      msk = (n == 0) ? 15'd0 : 15'((32'd1 << (n - 1)) - 1);
      if (te) begin                                   // R9
         m_cnt = m_cnt + 15'd1;
         ev    = (n != 0) && ((m_cnt & msk) == 15'd0); // R3, R5
      end
      if (ev)       m_flag = 1'b1;                    // R6, R7
      else if (clr) m_flag = 1'b0;
      e.f   = m_flag;
      e.i   = en & m_flag;                            // R8
      e.tag = tag;
      exp_q.push_back(e);
      @(negedge clk);
   endtask

   // Monitor: compares one quarter period after each edge.
   always @(posedge clk) begin
      #(CLK_P/4);
      if (!done && exp_q.size() > 0) begin
         exp_t e;
         e = exp_q.pop_front();
         n_vec++;
         if (per_flag !== e.f || irq_req !== e.i) begin
            n_miss++;
            $display("FAIL %s: flag/irq actual %b/%b expected %b/%b at %0t",
                     e.tag, per_flag, irq_req, e.f, e.i, $time);
         end
      end
   end

   task automatic report_and_end();
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_miss);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_miss++;
      $display("FAIL watchdog: actual hung expected finished");
      report_and_end();
   end

   initial begin
      rst_n = 1'b0; tick_en = 1'b0; rate_sel = 4'd0; per_en = 1'b0; flag_clr = 1'b0;
      m_cnt = '0; m_flag = 1'b0;
      repeat (3) @(negedge clk);

      // R1: reset state.
      n_vec++;
      if (per_flag !== 1'b0 || irq_req !== 1'b0) begin
         n_miss++;
         $display("FAIL R1: flag/irq actual %b/%b expected 0/0", per_flag, irq_req);
      end
      rst_n = 1'b1;

      // R1, R3: a count that starts at zero puts the first code-3 event on pulse 4.
      for (int k = 0; k < 12; k++) step(1'b1, 4'd3, 1'b1, 1'b0, "R1");
      step(1'b0, 4'd3, 1'b1, 1'b1, "R6");

      // R2: code 0 stays silent.
      for (int k = 0; k < 60; k++) step(1'b1, 4'd0, 1'b1, 1'b0, "R2");

      // R3: code 3 with periodic clears.
      for (int k = 0; k < 40; k++) step(1'b1, 4'd3, 1'b1, (k % 3) == 0, "R3");

      // R3: the longest period, code 15.
      for (int k = 0; k < 17000; k++) step(1'b1, 4'd15, 1'b1, (k % 500) == 0, "R3");

      // R4: the aliased codes, with the direct codes for comparison.
      for (int k = 0; k < 300; k++) step(1'b1, 4'd1, 1'b1, (k % 7) == 0, "R4");
      for (int k = 0; k < 300; k++) step(1'b1, 4'd8, 1'b1, (k % 7) == 0, "R4");
      for (int k = 0; k < 600; k++) step(1'b1, 4'd2, 1'b1, (k % 7) == 0, "R4");
      for (int k = 0; k < 600; k++) step(1'b1, 4'd9, 1'b1, (k % 7) == 0, "R4");

      // R5: change the rate mid-count; the phase is kept.
      for (int k = 0; k < 13; k++) step(1'b1, 4'd7, 1'b1, 1'b1, "R5");
      for (int k = 0; k < 80; k++) step(1'b1, 4'd6, 1'b1, 1'b1, "R5");
      for (int k = 0; k < 5;  k++) step(1'b1, 4'd4, 1'b1, 1'b1, "R5");

      // R6: the flag rises with the enable off and holds without a clear.
      step(1'b0, 4'd4, 1'b0, 1'b1, "R6");
      for (int k = 0; k < 40; k++) step(1'b1, 4'd4, 1'b0, 1'b0, "R6");

      // R8: setting the enable over a pending flag raises the request.
      for (int k = 0; k < 4; k++) step(1'b0, 4'd4, 1'b1, 1'b0, "R8");
      step(1'b0, 4'd4, 1'b0, 1'b0, "R8");
      step(1'b0, 4'd4, 1'b1, 1'b1, "R8");

      // R7: the clear is held high across events.
      for (int k = 0; k < 40; k++) step(1'b1, 4'd3, 1'b1, 1'b1, "R7");

      // R9: sparse pulses; the count freezes in between.
      for (int k = 0; k < 90; k++) step((k % 3) == 0, 4'd3, 1'b1, (k % 5) == 0, "R9");

      step(1'b0, 4'd3, 1'b1, 1'b0, "R9");
      @(negedge clk);
      report_and_end();
   end

endmodule